// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block generates the raster timing for a display from a set of horizontal and vertical timing values that are loaded through a word-wide register write port. A pixel counter and a line counter run from the pixel clock. Compare windows on these two counters drive the blanking and sync outputs for a CRT, plus a separate horizontal and vertical sync pair for a flat panel. A combinational flag marks the visible area. An interlaced mode is available. In that mode the line counter advances at the middle and at the end of each scan line, so each field covers an odd number of half-lines and the field indicator toggles at each vertical wrap.

Each 32-bit write word carries two 11-bit fields. Writes first land in a shadow copy. The counters and compares run on a separate live copy, which takes the shadow contents and the interlace request only at a frame boundary. Every start, end and total value is stored one below the count at which it acts. The flat-panel vertical sync values are stored two below. The internal flat-panel vertical window is passed to its output once per line, one pixel after the flat-panel horizontal sync rises.

Top module: `vtg_top`

## Requirements
- R1: Word index selects the timing pair: 0 pixel total/active, 1 horizontal blank end/start, 2 CRT horizontal sync end/start, 3 flat-panel horizontal sync end/start, 4 line total/active, 5 vertical blank end/start, 6 CRT vertical sync end/start, 7 flat-panel vertical sync end/start. The end or total value is taken from bits 26:16 and the start or active value from bits 10:0. All other bits are ignored.
- R2: The pixel counter runs from 0 up to the pixel total and then wraps to 0. It advances by one on every clock.
- R3: In progressive mode the line counter advances by one when the pixel counter wraps. It goes back to 0 after it reaches the line total.
- R4: Horizontal blank, CRT horizontal sync and flat-panel horizontal sync are high while the pixel count c satisfies start < c <= end. If end < start the window wraps, so the output is high for c > start or c <= end.
- R5: Vertical blank and CRT vertical sync are high while the line count v satisfies start < v <= end, with the same wrap rule as R4.
- R6: The internal flat-panel vertical window is high for start+1 < v <= end+1. The flat-panel vertical sync output takes the value of this window one clock after each rise of the flat-panel horizontal sync, and changes at no other time.
- R7: Active video is high exactly when the pixel count is at most the pixel active value and the line count is at most the line active value.
- R8: In interlaced mode the line counter advances at the clock after the pixel count equals the pixel total shifted right by one, and again when the pixel counter wraps. The field bit toggles at each line-counter wrap. In progressive mode the field bit is 0.
- R9: Written values and the interlace request take effect at the line-counter wrap that ends a frame. In progressive mode this is every wrap. In interlaced mode it is only the wrap that ends field 1. Before that point the old timing keeps running.
- R10: On reset both counters and every sync, blank and field output are 0. The live timing is loaded from a parameter, and the block starts in progressive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| intl_en_i | input | 1 | Interlace request, sampled at a frame boundary |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Timing word index |
| wr_data_i | input | 32 | Timing word with two 11-bit fields |
| h_blank_o | output | 1 | Horizontal blank |
| v_blank_o | output | 1 | Vertical blank |
| crt_hsync_o | output | 1 | CRT horizontal sync |
| crt_vsync_o | output | 1 | CRT vertical sync |
| fp_hsync_o | output | 1 | Flat-panel horizontal sync |
| fp_vsync_o | output | 1 | Flat-panel vertical sync, latched once per line |
| active_o | output | 1 | Visible area flag |
| field_o | output | 1 | Current interlace field |
| h_count_o | output | 11 | Pixel counter |
| v_count_o | output | 11 | Line counter (half-lines when interlaced) |

## Verification
The hardest case to reach is the interlaced frame boundary. There the live timing must ignore the wrap that ends field 0 and reload only at the wrap that ends field 1, and one of those wraps falls in the middle of a line. The stimulus writes a new interlaced timing set during a progressive frame. While field 0 of that interlaced frame is running, it writes the progressive set back. Every output is compared on every clock against the counters that the bench derives by arithmetic from the elapsed cycle count. A reload at the wrong wrap therefore shifts sync positions that the bench predicts exactly.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int CW     = 11;             // field width of every timing value
    localparam int DW     = 32;             // write word width
    localparam int NREG   = 8;              // timing words
    localparam int AW     = $clog2(NREG);
    localparam int HI_LSB = 16;             // end / total field position
    localparam int LO_LSB = 0;              // start / active field position
    localparam int NWIN   = 6;              // compare windows

    typedef logic [CW-1:0] cnt_t;

    typedef struct packed {
        cnt_t hi;                           // end or total
        cnt_t lo;                           // start or active
    } pair_t;

    typedef enum logic [AW-1:0] {
        REG_H_SIZE     = 3'd0,
        REG_H_BLANK    = 3'd1,
        REG_H_CRT_SYNC = 3'd2,
        REG_H_FP_SYNC  = 3'd3,
        REG_V_SIZE     = 3'd4,
        REG_V_BLANK    = 3'd5,
        REG_V_CRT_SYNC = 3'd6,
        REG_V_FP_SYNC  = 3'd7
    } reg_idx_e;

    typedef enum int {
        W_HBLANK = 0,
        W_HSYNC  = 1,
        W_FPH    = 2,
        W_VBLANK = 3,
        W_VSYNC  = 4,
        W_FPV    = 5
    } win_e;

    localparam int NHWIN = 3;               // windows below this index run on pixels

    typedef pair_t [NREG-1:0] timing_t;

    typedef struct packed {
        timing_t shadow;
        timing_t live;
        logic    intl;
    } reg_state_t;

    typedef struct packed {
        cnt_t hc;
        cnt_t vc;
        logic field;
    } cnt_state_t;

    function automatic pair_t mk_pair(int hi, int lo);
        pair_t p;
        p.hi = cnt_t'(hi);
        p.lo = cnt_t'(lo);
        return p;
    endfunction

    function automatic timing_t default_timing();
        timing_t t;
        t[REG_H_SIZE]     = mk_pair(19, 11);
        t[REG_H_BLANK]    = mk_pair(19, 11);
        t[REG_H_CRT_SYNC] = mk_pair(16, 13);
        t[REG_H_FP_SYNC]  = mk_pair(17, 14);
        t[REG_V_SIZE]     = mk_pair(9, 5);
        t[REG_V_BLANK]    = mk_pair(9, 5);
        t[REG_V_CRT_SYNC] = mk_pair(7, 6);
        t[REG_V_FP_SYNC]  = mk_pair(7, 6);
        return t;
    endfunction

    localparam timing_t DEFAULT_TIMING = default_timing();

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter timing_t RESET_TIMING = DEFAULT_TIMING
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          load_i,
    input  logic          intl_req_i,
    output timing_t       live_o,
    output logic          intl_o
);

    reg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            state_d.shadow[wr_addr_i].hi = wr_data_i[HI_LSB +: CW];
            state_d.shadow[wr_addr_i].lo = wr_data_i[LO_LSB +: CW];
        end
        // the live copy takes the shadow as it stood before this cycle's write
        if (load_i) begin
            state_d.live = state_q.shadow;
            state_d.intl = intl_req_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.shadow <= RESET_TIMING;
            state_q.live   <= RESET_TIMING;
            state_q.intl   <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign live_o = state_q.live;
    assign intl_o = state_q.intl;

endmodule

// File: rtl/vtg_counters.sv
module vtg_counters
    import vtg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  cnt_t h_total_i,
    input  cnt_t v_total_i,
    input  logic intl_i,
    output cnt_t hc_o,
    output cnt_t vc_o,
    output logic field_o,
    output logic vstep_o,
    output logic frame_end_o
);

    cnt_state_t state_d, state_q;
    logic       eol;
    logic       mid;
    logic       vwrap;

    always_comb begin
        state_d     = state_q;
        eol         = (state_q.hc == h_total_i);
        mid         = intl_i && (state_q.hc == (h_total_i >> 1));
        vstep_o     = eol || mid;
        vwrap       = vstep_o && (state_q.vc == v_total_i);
        frame_end_o = vwrap && (!intl_i || state_q.field);

        state_d.hc = eol ? '0 : cnt_t'(state_q.hc + 1'b1);
        if (vstep_o) begin
            state_d.vc = vwrap ? '0 : cnt_t'(state_q.vc + 1'b1);
        end
        if (vwrap) begin
            state_d.field = intl_i ? ~state_q.field : 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign hc_o    = state_q.hc;
    assign vc_o    = state_q.vc;
    assign field_o = state_q.field;

endmodule

// File: rtl/vtg_window.sv
module vtg_window
    import vtg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  cnt_t cnt_i,
    input  cnt_t start_i,
    input  cnt_t stop_i,
    input  logic step_i,
    output logic flag_o
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (step_i) begin
            if (cnt_i == start_i) begin
                flag_d = 1'b1;
            end
            if (cnt_i == stop_i) begin
                flag_d = 1'b0;                  // clear wins a tie
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter timing_t RESET_TIMING = DEFAULT_TIMING
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          intl_en_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          h_blank_o,
    output logic          v_blank_o,
    output logic          crt_hsync_o,
    output logic          crt_vsync_o,
    output logic          fp_hsync_o,
    output logic          fp_vsync_o,
    output logic          active_o,
    output logic          field_o,
    output logic [CW-1:0] h_count_o,
    output logic [CW-1:0] v_count_o
);

    timing_t live;
    logic    intl_live;
    cnt_t    hc, vc;
    logic    vstep;
    logic    frame_end;

    cnt_t    win_cnt   [NWIN];
    cnt_t    win_start [NWIN];
    cnt_t    win_stop  [NWIN];
    logic    win_step  [NWIN];
    logic    win_flag  [NWIN];

    logic    fpv_d, fpv_q;
    logic    fph_d, fph_q;

    vtg_regs #(
        .RESET_TIMING(RESET_TIMING)
    ) regs_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .load_i     (frame_end),
        .intl_req_i (intl_en_i),
        .live_o     (live),
        .intl_o     (intl_live)
    );

    vtg_counters cnt_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .h_total_i   (live[REG_H_SIZE].hi),
        .v_total_i   (live[REG_V_SIZE].hi),
        .intl_i      (intl_live),
        .hc_o        (hc),
        .vc_o        (vc),
        .field_o     (field_o),
        .vstep_o     (vstep),
        .frame_end_o (frame_end)
    );

    // window sources: pixel windows first, then line windows
    always_comb begin
        win_start[W_HBLANK] = live[REG_H_BLANK].lo;
        win_stop [W_HBLANK] = live[REG_H_BLANK].hi;
        win_start[W_HSYNC]  = live[REG_H_CRT_SYNC].lo;
        win_stop [W_HSYNC]  = live[REG_H_CRT_SYNC].hi;
        win_start[W_FPH]    = live[REG_H_FP_SYNC].lo;
        win_stop [W_FPH]    = live[REG_H_FP_SYNC].hi;
        win_start[W_VBLANK] = live[REG_V_BLANK].lo;
        win_stop [W_VBLANK] = live[REG_V_BLANK].hi;
        win_start[W_VSYNC]  = live[REG_V_CRT_SYNC].lo;
        win_stop [W_VSYNC]  = live[REG_V_CRT_SYNC].hi;
        // flat-panel vertical values sit two below the line, one more than the rest
        win_start[W_FPV]    = cnt_t'(live[REG_V_FP_SYNC].lo + 1'b1);
        win_stop [W_FPV]    = cnt_t'(live[REG_V_FP_SYNC].hi + 1'b1);
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        if (w < NHWIN) begin : g_pix
            assign win_cnt[w]  = hc;
            assign win_step[w] = 1'b1;
        end else begin : g_line
            assign win_cnt[w]  = vc;
            assign win_step[w] = vstep;
        end
        vtg_window win_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .cnt_i   (win_cnt[w]),
            .start_i (win_start[w]),
            .stop_i  (win_stop[w]),
            .step_i  (win_step[w]),
            .flag_o  (win_flag[w])
        );
    end

    // flat-panel vertical output follows the internal window once per line
    always_comb begin
        fph_d = win_flag[W_FPH];
        fpv_d = fpv_q;
        if (win_flag[W_FPH] && !fph_q) begin
            fpv_d = win_flag[W_FPV];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fpv_q <= 1'b0;
            fph_q <= 1'b0;
        end else begin
            fpv_q <= fpv_d;
            fph_q <= fph_d;
        end
    end

    assign h_blank_o   = win_flag[W_HBLANK];
    assign crt_hsync_o = win_flag[W_HSYNC];
    assign fp_hsync_o  = win_flag[W_FPH];
    assign v_blank_o   = win_flag[W_VBLANK];
    assign crt_vsync_o = win_flag[W_VSYNC];
    assign fp_vsync_o  = fpv_q;
    assign active_o    = (hc <= live[REG_H_SIZE].lo) && (vc <= live[REG_V_SIZE].lo);
    assign h_count_o   = hc;
    assign v_count_o   = vc;

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
    import vtg_pkg::*;
(
    input logic    clk_i,
    input logic    rst_ni,
    input cnt_t    h_count,
    input cnt_t    v_count,
    input timing_t live,
    input logic    intl,
    input logic    field,
    input logic    fp_hsync,
    input logic    fp_vsync
);

    cnt_t h_total, v_total;
    assign h_total = live[REG_H_SIZE].hi;
    assign v_total = live[REG_V_SIZE].hi;

    a_r2_h_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (h_count == h_total) |=> (h_count == '0));

    a_r2_h_incr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (h_count != h_total) |=> (h_count == cnt_t'($past(h_count) + 1'b1)));

    a_r3_v_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((h_count != h_total) && !(intl && (h_count == (h_total >> 1))))
        |=> $stable(v_count));

    a_r3_v_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        v_count <= v_total);

    a_r6_fpv_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(fp_vsync) |-> ($past(fp_hsync) && !$past(fp_hsync, 2)));

    a_r8_field_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !intl |-> !field);

    a_r9_live_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(live) |-> $past((h_count == h_total) && (v_count == v_total)));

endmodule

bind vtg_top vtg_checker chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .h_count  (h_count_o),
    .v_count  (v_count_o),
    .live     (live),
    .intl     (intl_live),
    .field    (field_o),
    .fp_hsync (fp_hsync_o),
    .fp_vsync (fp_vsync_o)
);

// File: tb/vtg_top_tb_top.sv
`timescale 1ns/1ps
module vtg_top_tb_top;
    import vtg_pkg::*;

    localparam int PH2   = 200;          // first progressive frame: 20 px x 10 lines
    localparam int PH3   = PH2 + 420;    // one interlaced frame: two fields of 21 half-lines
    localparam int T_END = PH3 + 400;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          intl_en_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic [DW-1:0] wr_data_i = '0;
    logic          h_blank_o, v_blank_o, crt_hsync_o, crt_vsync_o;
    logic          fp_hsync_o, fp_vsync_o, active_o, field_o;
    logic [CW-1:0] h_count_o, v_count_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    // progressive set (also the reset set) and interlaced set, per word index
    int hi_a [8] = '{19, 19, 16, 17, 9, 9, 7, 7};
    int lo_a [8] = '{11, 11, 13, 14, 5, 5, 6, 6};
    int hi_b [8] = '{19, 19, 5, 6, 20, 20, 19, 19};
    int lo_b [8] = '{11, 11, 2, 3, 17, 18, 18, 18};

    always #2 clk_i = ~clk_i;

    vtg_top dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .intl_en_i   (intl_en_i),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .h_blank_o   (h_blank_o),
        .v_blank_o   (v_blank_o),
        .crt_hsync_o (crt_hsync_o),
        .crt_vsync_o (crt_vsync_o),
        .fp_hsync_o  (fp_hsync_o),
        .fp_vsync_o  (fp_vsync_o),
        .active_o    (active_o),
        .field_o     (field_o),
        .h_count_o   (h_count_o),
        .v_count_o   (v_count_o)
    );

    function automatic bit in_win(int c, int s, int e);
        if (s < e) return (c > s) && (c <= e);
        return (c > s) || (c <= e);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pack_word(int hi, int lo);
        // reserved bits filled with ones (R1: ignored)
        return {5'h1F, 11'(hi), 5'h1F, 11'(lo)};
    endfunction

    initial begin
        bit exp_fpv;
        exp_fpv = 1'b0;
        repeat (3) @(negedge clk_i);
        // R10: state held in reset
        check("R10", "h_count", int'(h_count_o), 0);
        check("R10", "v_count", int'(v_count_o), 0);
        check("R10", "syncs+blanks+field",
              int'({h_blank_o, v_blank_o, crt_hsync_o, crt_vsync_o, fp_hsync_o, fp_vsync_o, field_o}), 0);
        rst_ni = 1'b1;
        for (int t = 0; t < T_END; t++) begin
            int    base;
            bit    il;
            int    hi [8];
            int    lo [8];
            int    u, len, hc, line, steps, vc, fld;
            string tag;
            if (t < PH2) begin
                base = 0;   il = 1'b0; hi = hi_a; lo = lo_a; tag = "";
            end else if (t < PH3) begin
                base = PH2; il = 1'b1; hi = hi_b; lo = lo_b; tag = " R1 R9";
            end else begin
                base = PH3; il = 1'b0; hi = hi_a; lo = lo_a; tag = " R9";
            end
            u     = t - base;
            len   = hi[0] + 1;
            hc    = u % len;
            line  = u / len;
            steps = il ? (2 * line + ((hc > hi[0] / 2) ? 1 : 0)) : line;
            vc    = steps % (hi[4] + 1);
            fld   = il ? ((steps / (hi[4] + 1)) % 2) : 0;
            // R6: output takes the internal window one clock after fp hsync rises
            if (hc == lo[3] + 2) exp_fpv = in_win(vc, lo[7] + 1, hi[7] + 1);

            check({"R2", tag}, "h_count", int'(h_count_o), hc);
            check({il ? "R8" : "R3", tag}, "v_count", int'(v_count_o), vc);
            check({"R4", tag}, "h_blank", int'(h_blank_o), int'(in_win(hc, lo[1], hi[1])));
            check({"R4", tag}, "crt_hsync", int'(crt_hsync_o), int'(in_win(hc, lo[2], hi[2])));
            check({"R4", tag}, "fp_hsync", int'(fp_hsync_o), int'(in_win(hc, lo[3], hi[3])));
            check({"R5", tag}, "v_blank", int'(v_blank_o), int'(in_win(vc, lo[5], hi[5])));
            check({"R5", tag}, "crt_vsync", int'(crt_vsync_o), int'(in_win(vc, lo[6], hi[6])));
            check({"R6", tag}, "fp_vsync", int'(fp_vsync_o), int'(exp_fpv));
            check({"R7", tag}, "active", int'(active_o), int'((hc <= lo[0]) && (vc <= lo[4])));
            check({"R8", tag}, "field", int'(field_o), fld);

            // R9: writes made mid-frame must wait for the frame boundary
            wr_en_i = 1'b0;
            if (t >= 5 && t < 13) begin
                wr_en_i   = 1'b1;
                wr_addr_i = AW'(t - 5);
                wr_data_i = pack_word(hi_b[t - 5], lo_b[t - 5]);
                intl_en_i = 1'b1;
            end else if (t >= PH2 + 20 && t < PH2 + 28) begin
                wr_en_i   = 1'b1;
                wr_addr_i = AW'(t - PH2 - 20);
                wr_data_i = pack_word(hi_a[t - PH2 - 20], lo_a[t - PH2 - 20]);
                intl_en_i = 1'b0;
            end
            @(posedge clk_i);
            @(negedge clk_i);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule